// File: doc/BRIEF.md
# Transaction Action Sequencer

This block drives a single cache transaction from start to finish. When a start command arrives, it loads a short queue of micro-action codes that belongs to the chosen transaction kind. It then offers those codes one at a time to the pipeline around it. Each offered action is held until the pipeline reports it done.

Two response counters gate progress. One counts expected completion acknowledgements from the requester. The other counts expected read-data responses from downstream. A blocking queue entry is offered only when both counters are zero. An entry marked non-blocking may be offered while responses are still awaited. When the queue is drained and nothing more is expected, the block emits a one-cycle finalize pulse, which frees the transaction slot.

The block raises a one-cycle flag in two cases: a start command that arrives while a transaction is in flight, and a response of a kind that nobody is waiting for.

Top module: `txn_action_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, actValid, finalize, busyErr and rspErr are all low.
- R2: With startKind=0 (read-shared hit), the offered codes are, in order: 1 tag read, 2 hit-pipeline delay, 3 data read, 4 send completion data, 5 wait for completion acknowledgement, and 6 tag write. Only the last of these is non-blocking.
- R3: With startKind=1 (read-shared miss), the offered codes are, in order: 7 miss-pipeline delay, 1 tag read, 8 send read-shared downstream, 4 send completion data, 5 wait for acknowledgement, 9 check cache fill, and 6 tag write. All of these are blocking.
- R4: An offered action keeps actValid high and actCode unchanged until actDone is sampled high. The next entry is considered only after that.
- R5: A blocking entry is not offered while either expected-response count is non-zero.
- R6: Completion of code 5 adds one expected acknowledgement (rspKind=0). Completion of code 8 adds one expected read-data response (rspKind=1). A matching response removes one.
- R7: A non-blocking entry is offered even while responses are still expected.
- R8: finalize is a one-cycle pulse. It is high in the second cycle after the later of two events: the last action's done is sampled, or the last expected response is sampled. Afterwards the block is idle and accepts a new start.
- R9: A start command sampled while a transaction is active is ignored, and busyErr pulses high in the following cycle.
- R10: A response whose kind has a zero expected count pulses rspErr in the following cycle and leaves both counts unchanged.
- R11: A start sampled while idle makes the first action valid in the second cycle after the start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a transaction |
| startKind | input | 1 | 0 read-shared hit, 1 read-shared miss |
| rspValid | input | 1 | Response arrival strobe |
| rspKind | input | 1 | 0 completion acknowledgement, 1 read data |
| actDone | input | 1 | Currently offered action has completed |
| actValid | output | 1 | An action is being offered |
| actCode | output | 4 | Code of the offered action |
| finalize | output | 1 | Transaction finished; slot may be released |
| busyErr | output | 1 | Start ignored because a transaction is active |
| rspErr | output | 1 | Response of an unexpected kind |

## Verification
The hit sequence is run with an acknowledgement that is held back until after the non-blocking tag write. This separates a block that honours the non-blocking bit from one that stalls the tag write, and it also checks that finalize waits for the acknowledgement. The miss sequence withholds the read data after the downstream request and withholds the acknowledgement before the cache-fill check. This shows whether each counter, on its own, blocks ordinary entries. One action is held undone for several cycles to confirm that the offer stays put. Stray responses and a second start are injected in mid-run and while idle; the checks confirm they raise their flags and leave the running sequence untouched.

// File: rtl/txn_action_seq_pkg.sv
package txn_action_seq_pkg;

  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] act_code_t;

  localparam act_code_t ACT_TAG_RD     = 4'd1;
  localparam act_code_t ACT_HIT_PIPE   = 4'd2;
  localparam act_code_t ACT_DATA_RD    = 4'd3;
  localparam act_code_t ACT_SEND_COMP  = 4'd4;
  localparam act_code_t ACT_WAIT_ACK   = 4'd5;
  localparam act_code_t ACT_TAG_WR     = 4'd6;
  localparam act_code_t ACT_MISS_PIPE  = 4'd7;
  localparam act_code_t ACT_SEND_RDSH  = 4'd8;
  localparam act_code_t ACT_CHECK_FILL = 4'd9;

  typedef struct packed {
    logic      nb;
    act_code_t code;
  } act_entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic kind;
    logic pop;
  } seq_strb_t;

  function automatic int listLen(input logic kind);
    return kind ? 7 : 6;
  endfunction

  function automatic act_entry_t listEntry(input logic kind, input int idx);
    act_entry_t e;
    e = '0;
    if (!kind) begin
      case (idx)
        0: e.code = ACT_TAG_RD;
        1: e.code = ACT_HIT_PIPE;
        2: e.code = ACT_DATA_RD;
        3: e.code = ACT_SEND_COMP;
        4: e.code = ACT_WAIT_ACK;
        5: begin e.code = ACT_TAG_WR; e.nb = 1'b1; end
        default: e = '0;
      endcase
    end else begin
      case (idx)
        0: e.code = ACT_MISS_PIPE;
        1: e.code = ACT_TAG_RD;
        2: e.code = ACT_SEND_RDSH;
        3: e.code = ACT_SEND_COMP;
        4: e.code = ACT_WAIT_ACK;
        5: e.code = ACT_CHECK_FILL;
        6: e.code = ACT_TAG_WR;
        default: e = '0;
      endcase
    end
    return e;
  endfunction

endpackage

// File: rtl/txn_action_seq_dp.sv
module txn_action_seq_dp
  import txn_action_seq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  seq_strb_t strb,
  input  logic      rspValid,
  input  logic      rspKind,
  output act_code_t headCode,
  output logic      headNb,
  output logic      qEmpty,
  output logic      pendZero,
  output logic      rspErr
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;

  act_entry_t        qMem [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  ackCnt, datCnt;
  act_entry_t        headEntry;
  logic              ackInc, datInc, ackDec, datDec, ackStray, datStray;

  assign headEntry = qMem[head[IDX_W-1:0]];
  assign headCode  = headEntry.code;
  assign headNb    = headEntry.nb;
  assign qEmpty    = (head == tail);
  assign pendZero  = (ackCnt == '0) && (datCnt == '0);

  assign ackInc   = strb.pop && (headCode == ACT_WAIT_ACK);
  assign datInc   = strb.pop && (headCode == ACT_SEND_RDSH);
  assign ackStray = rspValid && !rspKind && (ackCnt == '0);
  assign datStray = rspValid &&  rspKind && (datCnt == '0);
  assign ackDec   = rspValid && !rspKind && !ackStray;
  assign datDec   = rspValid &&  rspKind && !datStray;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) qMem[i] <= '0;
      head   <= '0;
      tail   <= '0;
      ackCnt <= '0;
      datCnt <= '0;
    end else if (strb.load) begin
      for (int i = 0; i < DEPTH; i++) qMem[i] <= listEntry(strb.kind, i);
      head   <= '0;
      tail   <= PTR_W'(listLen(strb.kind));
      ackCnt <= '0;
      datCnt <= '0;
    end else begin
      if (strb.pop) head <= head + 1'b1;
      ackCnt <= ackCnt + CNT_W'(ackInc) - CNT_W'(ackDec);
      datCnt <= datCnt + CNT_W'(datInc) - CNT_W'(datDec);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspErr <= 1'b0;
    else       rspErr <= ackStray || datStray;
  end

endmodule

// File: rtl/txn_action_seq_ctrl.sv
module txn_action_seq_ctrl
  import txn_action_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      startKind,
  input  logic      actDone,
  input  logic      qEmpty,
  input  logic      pendZero,
  input  logic      headNb,
  output seq_strb_t strb,
  output logic      actValid,
  output logic      finalize,
  output logic      busyErr
);
  logic active, issuing, canIssue, allDone;

  assign canIssue  = active && !issuing && !qEmpty && (pendZero || headNb);
  assign allDone   = active && !issuing && qEmpty && pendZero;
  assign strb.load = startReq && !active;
  assign strb.kind = startKind;
  assign strb.pop  = issuing && actDone;
  assign actValid  = issuing;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      issuing  <= 1'b0;
      finalize <= 1'b0;
      busyErr  <= 1'b0;
    end else begin
      busyErr  <= startReq && active;
      finalize <= allDone;
      if (strb.load)    active <= 1'b1;
      else if (allDone) active <= 1'b0;
      if (canIssue)      issuing <= 1'b1;
      else if (strb.pop) issuing <= 1'b0;
    end
  end

endmodule

// File: rtl/txn_action_seq.sv
module txn_action_seq
  import txn_action_seq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic            startKind,
  input  logic            rspValid,
  input  logic            rspKind,
  input  logic            actDone,
  output logic            actValid,
  output logic [CODE_W-1:0] actCode,
  output logic            finalize,
  output logic            busyErr,
  output logic            rspErr
);
  seq_strb_t strb;
  logic      qEmpty, pendZero, headNb;
  act_code_t headCode;

  txn_action_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startKind(startKind),
    .actDone(actDone), .qEmpty(qEmpty), .pendZero(pendZero), .headNb(headNb),
    .strb(strb), .actValid(actValid), .finalize(finalize), .busyErr(busyErr)
  );

  txn_action_seq_dp #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rspValid(rspValid), .rspKind(rspKind),
    .headCode(headCode), .headNb(headNb), .qEmpty(qEmpty), .pendZero(pendZero),
    .rspErr(rspErr)
  );

  assign actCode = headCode;

endmodule

// File: rtl/txn_action_seq_chk.sv
module txn_action_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startReq,
  input logic       startKind,
  input logic       rspValid,
  input logic       rspKind,
  input logic       actDone,
  input logic       actValid,
  input logic [3:0] actCode,
  input logic       finalize,
  input logic       busyErr,
  input logic       rspErr
);
  // R4
  hold_until_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    actValid && !actDone |=> actValid && $stable(actCode));

  // R8
  finalize_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    finalize |=> !finalize);

  // R8
  finalize_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    finalize |-> !actValid);

  // R9
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyErr |-> $past(startReq));

  // R10
  rsp_err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> $past(rspValid));

endmodule

bind txn_action_seq txn_action_seq_chk i_chk (.*);

// File: tb/test_txn_action_seq.sv
module test_txn_action_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, startKind = 1'b0;
  logic rspValid = 1'b0, rspKind = 1'b0, actDone = 1'b0;
  logic actValid, finalize, busyErr, rspErr;
  logic [3:0] actCode;
  int nChecks = 0, nFails = 0, cyc = 0;

  always #2 clk = ~clk;

  txn_action_seq i_txn_action_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startKind(startKind),
    .rspValid(rspValid), .rspKind(rspKind), .actDone(actDone),
    .actValid(actValid), .actCode(actCode), .finalize(finalize),
    .busyErr(busyErr), .rspErr(rspErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      finish();
    end
  end

  task automatic step(); @(negedge clk); endtask

  // wait for an offer, check its code, hold it undone, then complete it
  task automatic serve(input int exp, input int hold, input string req);
    int n = 0;
    while (!actValid && n < 40) begin step(); n++; end
    check(actValid && actCode == exp, req, actCode, exp);
    for (int i = 0; i < hold; i++) begin
      step();
      check(actValid && actCode == exp, "R4", actCode, exp);
    end
    actDone = 1'b1;
    step();
    actDone = 1'b0;
  endtask

  task automatic pulseRsp(input logic kind);
    rspKind = kind; rspValid = 1'b1;
    step();
    rspValid = 1'b0;
  endtask

  task automatic startTxn(input logic kind);
    startKind = kind; startReq = 1'b1;
    step();
    startReq = 1'b0;
  endtask

  task automatic testReset();
    check(!actValid && !finalize && !busyErr && !rspErr, "R1",
          {actValid, finalize, busyErr, rspErr}, 0);
  endtask

  task automatic testHit();
    startTxn(1'b0);
    check(!actValid, "R11", actValid, 0);
    step();
    check(actValid && actCode == 1, "R11", actCode, 1);
    serve(1, 3, "R2");
    serve(2, 0, "R2");
    serve(3, 0, "R2");
    serve(4, 0, "R2");
    serve(5, 0, "R2");
    serve(6, 0, "R7");
    for (int i = 0; i < 4; i++) begin
      check(!finalize && !actValid, "R8", finalize, 0);
      step();
    end
    pulseRsp(1'b0);
    check(!finalize, "R8", finalize, 0);
    step();
    check(finalize, "R8", finalize, 1);
    step();
    check(!finalize, "R8", finalize, 0);
  endtask

  task automatic testMiss();
    startTxn(1'b1);
    serve(7, 0, "R3");
    serve(1, 0, "R3");
    serve(8, 0, "R3");
    for (int i = 0; i < 5; i++) begin
      check(!actValid, "R5", actValid, 0);
      step();
    end
    pulseRsp(1'b1);
    check(!rspErr, "R6", rspErr, 0);
    serve(4, 0, "R3");
    serve(5, 0, "R3");
    for (int i = 0; i < 4; i++) begin
      check(!actValid, "R5", actValid, 0);
      step();
    end
    pulseRsp(1'b0);
    serve(9, 0, "R3");
    serve(6, 0, "R3");
    check(!finalize, "R8", finalize, 0);
    step();
    check(finalize, "R8", finalize, 1);
    step();
  endtask

  task automatic testBusy();
    startTxn(1'b0);
    serve(1, 0, "R2");
    startTxn(1'b1);
    check(busyErr, "R9", busyErr, 1);
    step();
    check(!busyErr, "R9", busyErr, 0);
    serve(2, 0, "R9");
    serve(3, 0, "R9");
    serve(4, 0, "R9");
    serve(5, 0, "R9");
    serve(6, 0, "R9");
    pulseRsp(1'b0);
    step();
    check(finalize, "R9", finalize, 1);
    step();
  endtask

  task automatic testStray();
    pulseRsp(1'b0);
    check(rspErr, "R10", rspErr, 1);
    step();
    check(!rspErr, "R10", rspErr, 0);
    pulseRsp(1'b1);
    check(rspErr, "R10", rspErr, 1);
    startTxn(1'b1);
    serve(7, 0, "R10");
    pulseRsp(1'b0);
    check(rspErr, "R10", rspErr, 1);
    serve(1, 0, "R10");
    serve(8, 0, "R10");
    pulseRsp(1'b1);
    check(!rspErr, "R10", rspErr, 0);
    serve(4, 0, "R10");
    serve(5, 0, "R10");
    pulseRsp(1'b0);
    serve(9, 0, "R10");
    serve(6, 0, "R10");
    step();
    check(finalize, "R10", finalize, 1);
    step();
  endtask

  initial begin
    step();
    testReset();
    step();
    rstN = 1'b1;
    step();
    testReset();
    testHit();
    testMiss();
    testBusy();
    testStray();
    finish();
  end
endmodule